// File: doc/BRIEF.md
# Page-Bounded Chained DMA Engine

A single-channel engine that copies 32-bit words between a streaming device port and memory without processor involvement. Software loads a device address, a memory start address and a byte count, then writes a control word that carries the direction and a start bit. From then on the engine requests the shared bus, moves one word for each bus cycle in which it holds the grant and the device side is ready, and raises an interrupt once the final word has moved.

A transfer never runs across a page boundary inside one bus tenure. The engine cuts the transfer at every page edge into segments. Each segment is arbitrated on its own, and the request is dropped between segments so that other masters can win the bus. Only the final segment ends in the completion interrupt. The interrupt stays high until software acknowledges it.

The memory port is treated as zero-wait-state: read data is valid in the same cycle that the read strobe and address are driven. While the device side stalls a read, the strobe may repeat for the same address.

Top module: `dma_page_chain`

## Requirements
- R1: After reset, busy, err, irq, bus_req, mem_we, mem_re, dev_in_ready and dev_out_valid are all 0.
- R2: A write with reg_sel=0 loads the device address, which then appears on dev_addr. reg_sel=1 loads the memory start address and reg_sel=2 loads the byte count. reg_sel=3 is the control word, with bit0 as start, bit1 as direction (0 = device to memory, 1 = memory to device) and bit2 as interrupt acknowledge.
- R3: A start is rejected when the byte count is zero, the count is not a multiple of 4, or the memory address is not word-aligned. A rejected start sets err, leaves busy at 0 and requests no bus. An accepted start clears err.
- R4: busy is 1 from the cycle after an accepted start. It falls in the same cycle that irq rises.
- R5: While busy, writes to reg_sel 0–2 and start requests have no effect. dev_addr does not change, and the running transfer keeps its original addresses and length.
- R6: With direction 0, each cycle with grant and dev_in_valid writes dev_in_data to mem_addr, pulses dev_in_ready, and steps the address by 4.
- R7: With direction 1, the engine drives mem_re and the word address while it holds the grant. mem_rdata is passed to dev_out_data with dev_out_valid, and the address steps by 4 only in cycles where dev_out_ready is 1.
- R8: No memory access happens in a cycle without bus_gnt. bus_req is held while the engine waits for grant and during a segment.
- R9: No segment crosses a page boundary (default 4096 bytes). After the word that ends a page, bus_req drops for at least one cycle before the next word moves.
- R10: Each segment moves the smaller of the remaining count and the bytes left to the next page boundary. Segment lengths are therefore the head up to the boundary, whole pages, then the tail.
- R11: irq rises after the last word of the whole transfer and stays high until a control write with bit2=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 device, 1 memory, 2 count, 3 control) |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last start request was rejected |
| irq | output | 1 | Completion interrupt |
| dev_addr | output | 32 | Programmed device address |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| mem_addr | output | 32 | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| dev_in_valid | input | 1 | Device offers a word to store |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Engine takes the offered word |
| dev_out_valid | output | 1 | Word for the device is valid |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device accepts the word |

## Verification
The transfers are chosen to separate the segmentation cases. A short transfer inside one page must form a single segment. A transfer starting 16 bytes before a page edge must split into 4 and 8 words. A read starting 8 bytes before an edge and spanning more than a page must split into 2, 1024 and 2 words under random device stalls, which separates wrong boundary arithmetic from wrong stall handling. A throttled write that starts one word before an edge checks the one-word head segment. Holding off the grant shows that the request is raised while no word moves. Zero, odd and misaligned start requests, and reprogramming during a live transfer, are checked for having no effect on what moves.

// File: rtl/dma_pc_pkg.sv
package dma_pc_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned CNT_W  = 20;

    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam int unsigned WORD_SH    = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        REG_DEV  = 2'd0,
        REG_MEM  = 2'd1,
        REG_CNT  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_GO  = 0;
    localparam int unsigned CTRL_DIR = 1;
    localparam int unsigned CTRL_ACK = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_MOVE,
        ST_GAP
    } eng_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dev_addr;
        logic [ADDR_W-1:0] mem_addr;
        logic [CNT_W-1:0]  byte_cnt;
    } dma_cfg_t;

    // A start is legal only for a non-empty, word-multiple count at a word-aligned address
    function automatic logic start_legal(input logic [CNT_W-1:0] cnt,
                                         input logic [ADDR_W-1:0] addr);
        return (cnt != '0) && (cnt[WORD_SH-1:0] == '0) && (addr[WORD_SH-1:0] == '0);
    endfunction

endpackage

// File: rtl/dma_pc_regs.sv
module dma_pc_regs
    import dma_pc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              done,
    output dma_cfg_t          cfg,
    output logic              go,
    output logic              go_dir,
    output logic              busy,
    output logic              err,
    output logic              irq
);

    logic ctrl_wr;
    logic go_req;
    logic ack_wr;

    always_comb begin
        ctrl_wr = wr_en && (sel == REG_CTRL);
        go_req  = ctrl_wr && wdata[CTRL_GO] && !busy;
        go      = go_req && start_legal(cfg.byte_cnt, cfg.mem_addr);
        go_dir  = wdata[CTRL_DIR];
        ack_wr  = ctrl_wr && wdata[CTRL_ACK];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            busy <= 1'b0;
            err  <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (wr_en && !busy) begin
                case (reg_sel_e'(sel))
                    REG_DEV: cfg.dev_addr <= wdata;
                    REG_MEM: cfg.mem_addr <= wdata;
                    REG_CNT: cfg.byte_cnt <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
            if (go_req) err <= !go;
            if (done)    busy <= 1'b0;
            else if (go) busy <= 1'b1;
            if (done)        irq <= 1'b1;
            else if (ack_wr) irq <= 1'b0;
        end
    end

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && (sel != REG_CTRL)) |=> $stable(cfg)); // R5

    AST_BAD_START_REJECT: assert property (@(posedge clk) disable iff (rst)
        (go_req && !start_legal(cfg.byte_cnt, cfg.mem_addr)) |=> (err && !busy)); // R3

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_wr) |=> irq); // R11

    AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy); // R4

endmodule

// File: rtl/dma_pc_seg.sv
module dma_pc_seg
    import dma_pc_pkg::*;
#(
    parameter  int unsigned PAGE_BYTES = 4096,
    localparam int unsigned PAGE_W     = $clog2(PAGE_BYTES),
    localparam int unsigned SEG_W      = PAGE_W - 1
) (
    input  logic [PAGE_W-1:0] page_off,
    input  logic [CNT_W-1:0]  rem_bytes,
    output logic [SEG_W-1:0]  seg_words
);

    localparam int unsigned LW = (CNT_W > PAGE_W) ? CNT_W + 1 : PAGE_W + 1;

    logic [LW-1:0] to_edge;
    logic [LW-1:0] rem_ext;
    logic [LW-1:0] take;

    always_comb begin
        to_edge   = LW'(PAGE_BYTES) - LW'(page_off);
        rem_ext   = LW'(rem_bytes);
        take      = (rem_ext < to_edge) ? rem_ext : to_edge;
        seg_words = SEG_W'(take >> WORD_SH);
    end

endmodule

// File: rtl/dma_pc_engine.sv
module dma_pc_engine
    import dma_pc_pkg::*;
#(
    parameter  int unsigned PAGE_BYTES = 4096,
    localparam int unsigned PAGE_W     = $clog2(PAGE_BYTES),
    localparam int unsigned SEG_W      = PAGE_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_dir,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [CNT_W-1:0]  go_cnt,
    input  logic [SEG_W-1:0]  seg_words,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  rem_bytes,
    output logic              done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready
);

    eng_state_e       st;
    logic [SEG_W-1:0] left_q;
    logic             dir_q;
    logic             in_move;
    logic             beat;
    logic             seg_end;
    logic             xfer_end;

    always_comb begin
        in_move       = (st == ST_MOVE);
        bus_req       = (st == ST_REQ) || in_move;
        mem_re        = in_move && bus_gnt && dir_q;
        dev_out_valid = mem_re;
        dev_out_data  = mem_rdata;
        dev_in_ready  = in_move && bus_gnt && !dir_q;
        mem_we        = dev_in_ready && dev_in_valid;
        mem_wdata     = dev_in_data;
        beat          = mem_we || (mem_re && dev_out_ready);
        seg_end       = (left_q == SEG_W'(1));
        xfer_end      = (rem_bytes == CNT_W'(WORD_BYTES));
        done          = beat && seg_end && xfer_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cur_addr  <= '0;
            rem_bytes <= '0;
            left_q    <= '0;
            dir_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    cur_addr  <= go_addr;
                    rem_bytes <= go_cnt;
                    dir_q     <= go_dir;
                    st        <= ST_REQ;
                end
                ST_REQ: if (bus_gnt) begin
                    left_q <= seg_words;
                    st     <= ST_MOVE;
                end
                ST_MOVE: if (beat) begin
                    cur_addr  <= cur_addr + ADDR_W'(WORD_BYTES);
                    rem_bytes <= rem_bytes - CNT_W'(WORD_BYTES);
                    left_q    <= left_q - SEG_W'(1);
                    if (seg_end) st <= xfer_end ? ST_IDLE : ST_GAP;
                end
                default: st <= ST_REQ;
            endcase
        end
    end

    AST_ACCESS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (bus_gnt && bus_req)); // R8

    AST_PAGE_END_BREAK: assert property (@(posedge clk) disable iff (rst)
        (beat && (&cur_addr[PAGE_W-1:WORD_SH])) |=> !(mem_we || mem_re)); // R9

    AST_READ_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mem_re && !dev_out_ready) |=> $stable(cur_addr)); // R7

endmodule

// File: rtl/dma_page_chain.sv
module dma_page_chain
    import dma_pc_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              busy,
    output logic              err,
    output logic              irq,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready
);

    localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
    localparam int unsigned SEG_W  = PAGE_W - 1;

    dma_cfg_t         cfg;
    logic             go;
    logic             go_dir;
    logic             done;
    logic [CNT_W-1:0] rem_bytes;
    logic [SEG_W-1:0] seg_words;

    dma_pc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .done   (done),
        .cfg    (cfg),
        .go     (go),
        .go_dir (go_dir),
        .busy   (busy),
        .err    (err),
        .irq    (irq)
    );

    dma_pc_seg #(.PAGE_BYTES(PAGE_BYTES)) u_seg (
        .page_off  (mem_addr[PAGE_W-1:0]),
        .rem_bytes (rem_bytes),
        .seg_words (seg_words)
    );

    dma_pc_engine #(.PAGE_BYTES(PAGE_BYTES)) u_engine (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .go_dir        (go_dir),
        .go_addr       (cfg.mem_addr),
        .go_cnt        (cfg.byte_cnt),
        .seg_words     (seg_words),
        .cur_addr      (mem_addr),
        .rem_bytes     (rem_bytes),
        .done          (done),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_re        (mem_re),
        .mem_rdata     (mem_rdata),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .dev_in_ready  (dev_in_ready),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_out_ready (dev_out_ready)
    );

    assign dev_addr = cfg.dev_addr;

endmodule

// File: tb/dma_page_chain_tb.sv
module dma_page_chain_tb;
    import dma_pc_pkg::*;

    localparam int unsigned TB_PAGE = 4096;

    logic        clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        busy, err, irq, bus_req;
    logic [31:0] dev_addr, mem_addr, mem_wdata, dev_out_data;
    logic        bus_gnt = 1'b0;
    logic        mem_we, mem_re, dev_in_ready, dev_out_valid;
    logic [31:0] mem_rdata;
    logic        dev_in_valid = 1'b0;
    logic [31:0] dev_in_data = 32'h1000_0000;
    logic        dev_out_ready = 1'b0;

    dma_page_chain #(.PAGE_BYTES(TB_PAGE)) u_dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .busy(busy), .err(err), .irq(irq), .dev_addr(dev_addr),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; } beat_t;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    beat_t exp_q[$];
    int    seg_log[$];
    int    seg_cnt = 0;
    bit    gap_seen = 1;
    bit    have_prev = 0;
    logic [31:0] prev_addr = 32'd0;
    beat_t mon_e;
    bit    gnt_en = 1;
    bit    throttle = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return {a[15:0], a[15:0] ^ 16'h5A5A};
    endfunction

    assign mem_rdata = rd_pat(mem_addr);

    // Grant model, device source and device sink
    always @(posedge clk) begin
        bus_gnt       <= rst ? 1'b0 : (bus_req & gnt_en);
        lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dev_in_valid  <= throttle ? lfsr[0] : 1'b1;
        dev_out_ready <= throttle ? lfsr[3] : 1'b1;
        if (dev_in_valid && dev_in_ready) dev_in_data <= dev_in_data + 32'd1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on every moved word
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we || (dev_out_valid && dev_out_ready)) begin
                chk(bus_gnt == 1'b1, "R8", "word moved without grant", {31'd0, bus_gnt}, 32'd1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, mem_we ? "R6" : "R7", "unexpected word", mem_addr, 32'd0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(mem_addr == mon_e.a, mem_we ? "R6" : "R7", "address", mem_addr, mon_e.a);
                    chk((mem_we ? mem_wdata : dev_out_data) == mon_e.d, mem_we ? "R6" : "R7",
                        "data", mem_we ? mem_wdata : dev_out_data, mon_e.d);
                end
                if (have_prev && (prev_addr / TB_PAGE) != (mem_addr / TB_PAGE))
                    chk(gap_seen, "R9", "page crossed inside one bus tenure", mem_addr, prev_addr);
                prev_addr = mem_addr;
                have_prev = 1;
                gap_seen  = 0;
                seg_cnt++;
            end
            if (!bus_req) begin
                gap_seen = 1;
                if (seg_cnt > 0) begin
                    seg_log.push_back(seg_cnt);
                    seg_cnt = 0;
                end
            end
        end
    end

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = s;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Driver: pushes the expected words, then programs and starts the engine
    task automatic start_xfer(input logic [31:0] maddr, input int cnt, input bit to_dev);
        for (int k = 0; k < cnt / 4; k++) begin
            beat_t b;
            b.a = maddr + 32'(4 * k);
            b.d = to_dev ? rd_pat(b.a) : dev_in_data + 32'(k);
            exp_q.push_back(b);
        end
        seg_log.delete();
        wr_reg(REG_MEM, maddr);
        wr_reg(REG_CNT, 32'(cnt));
        wr_reg(REG_CTRL, {30'd0, to_dev, 1'b1});
    endtask

    task automatic wait_done();
        int n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(irq == 1'b1, "R11", "irq after transfer", {31'd0, irq}, 32'd1);
        chk(busy == 1'b0, "R4", "busy falls with irq", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R6", "words left unmoved", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic chk_segs(input string req, input int s0, input int s1, input int s2, input int nseg);
        chk(seg_log.size() == nseg, req, "segment count", 32'(seg_log.size()), 32'(nseg));
        if (seg_log.size() > 0) chk(seg_log[0] == s0, req, "segment 0 words", 32'(seg_log[0]), 32'(s0));
        if (seg_log.size() > 1 && nseg > 1) chk(seg_log[1] == s1, req, "segment 1 words", 32'(seg_log[1]), 32'(s1));
        if (seg_log.size() > 2 && nseg > 2) chk(seg_log[2] == s2, req, "segment 2 words", 32'(seg_log[2]), 32'(s2));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk({busy, err, irq, bus_req, mem_we, mem_re, dev_in_ready, dev_out_valid} == 8'd0,
            "R1", "outputs after reset",
            {24'd0, busy, err, irq, bus_req, mem_we, mem_re, dev_in_ready, dev_out_valid}, 32'd0);

        // R2 device address register
        wr_reg(REG_DEV, 32'hD00D_0040);
        chk(dev_addr == 32'hD00D_0040, "R2", "dev_addr", dev_addr, 32'hD00D_0040);

        // R3 rejected starts: odd count, zero count, misaligned address
        wr_reg(REG_MEM, 32'h0000_0100);
        wr_reg(REG_CNT, 32'd6);
        wr_reg(REG_CTRL, 32'd1);
        chk(err == 1'b1, "R3", "err on odd count", {31'd0, err}, 32'd1);
        chk(busy == 1'b0, "R3", "busy on odd count", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk(bus_req == 1'b0, "R3", "bus_req after reject", {31'd0, bus_req}, 32'd0);
        wr_reg(REG_CNT, 32'd0);
        wr_reg(REG_CTRL, 32'd1);
        chk(err == 1'b1 && busy == 1'b0, "R3", "zero count rejected", {30'd0, err, busy}, 32'd2);
        wr_reg(REG_MEM, 32'h0000_0102);
        wr_reg(REG_CNT, 32'd8);
        wr_reg(REG_CTRL, 32'd1);
        chk(err == 1'b1 && busy == 1'b0, "R3", "misaligned address rejected", {30'd0, err, busy}, 32'd2);

        // R6 R4 R10 short write inside one page
        throttle = 0;
        start_xfer(32'h0000_0200, 16, 1'b0);
        chk(busy == 1'b1, "R4", "busy after start", {31'd0, busy}, 32'd1);
        chk(err == 1'b0, "R3", "err cleared by good start", {31'd0, err}, 32'd0);
        wait_done();
        chk_segs("R10", 4, 0, 0, 1);
        wr_reg(REG_CTRL, 32'd4);
        chk(irq == 1'b0, "R11", "irq acknowledged", {31'd0, irq}, 32'd0);

        // R9 R10 R11 write crossing one page edge
        start_xfer(32'h0000_0FF0, 48, 1'b0);
        wait_done();
        chk_segs("R10", 4, 8, 0, 2);
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R11", "irq held without acknowledge", {31'd0, irq}, 32'd1);
        wr_reg(REG_CTRL, 32'd4);
        chk(irq == 1'b0, "R11", "irq acknowledged", {31'd0, irq}, 32'd0);

        // R7 R5 R9 throttled multi-page read, reprogrammed while busy
        throttle = 1;
        start_xfer(32'h0000_1FF8, 4112, 1'b1);
        repeat (10) @(negedge clk);
        wr_reg(REG_DEV, 32'hBAD0_0000);
        wr_reg(REG_CNT, 32'd8);
        wr_reg(REG_MEM, 32'h0000_7000);
        wr_reg(REG_CTRL, 32'd1);
        chk(dev_addr == 32'hD00D_0040, "R5", "dev_addr changed while busy", dev_addr, 32'hD00D_0040);
        wait_done();
        chk_segs("R9", 2, 1024, 2, 3);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0 && bus_req == 1'b0, "R5", "restart while busy took effect",
            {30'd0, busy, bus_req}, 32'd0);
        wr_reg(REG_CTRL, 32'd4);

        // R8 grant withheld
        throttle = 0;
        gnt_en   = 0;
        start_xfer(32'h0000_3000, 8, 1'b0);
        repeat (15) @(negedge clk);
        chk(bus_req == 1'b1, "R8", "request held while waiting", {31'd0, bus_req}, 32'd1);
        chk(exp_q.size() == 2, "R8", "words moved without grant", 32'(exp_q.size()), 32'd2);
        gnt_en = 1;
        wait_done();
        wr_reg(REG_CTRL, 32'd4);

        // R10 R6 throttled write with a one-word head segment
        throttle = 1;
        start_xfer(32'h0000_4FFC, 12, 1'b0);
        wait_done();
        chk_segs("R10", 1, 2, 0, 2);
        wr_reg(REG_CTRL, 32'd4);
        chk(irq == 1'b0, "R11", "final acknowledge", {31'd0, irq}, 32'd0);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R4 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

endmodule